// File: doc/BRIEF.md
# Two-Layer Graphics Overlay Blender

This block stacks two graphics planes on a live background video stream just before the pixels leave for a display panel. Every clock cycle it receives one background pixel in RGB565, one 16-bit pixel from each plane, and one output pixel's worth of video markers: valid, horizontal sync and vertical sync.

Each plane has its own enable and its own format select. A plane in RGB565 format is an opaque layer. A plane in ARGB4444 format carries a 4-bit alpha in each pixel and is blended over the layers beneath it. Layer 2 sits on top of layer 1, and layer 1 sits on top of the video.

The result is one composited RGB565 pixel per cycle, two cycles after its inputs. The markers are delayed by the same two cycles, so downstream panel logic sees pixels and markers still aligned.

Top module: `overlay_blender`

## Requirements
- R1: Output pixel, valid, hsync and vsync appear exactly 2 clock cycles after the inputs they belong to, with the markers delayed by the same amount as the pixel.
- R2: With both planes disabled, the output pixel equals the background pixel.
- R3: An enabled plane with format select 0 (RGB565: red [15:11], green [10:5], blue [4:0]) is opaque and replaces everything beneath it.
- R4: Layer 2 is composited above layer 1, and layer 1 is composited above the background.
- R5: Format select 1 (ARGB4444) reads alpha from [15:12], red from [11:8], green from [7:4] and blue from [3:0]. Each component is widened by repeating its top bits: red and blue to 5 bits, green to 6 bits.
- R6: An ARGB4444 pixel with alpha 0 leaves the pixel beneath it unchanged.
- R7: An ARGB4444 pixel with alpha 15 replaces the pixel beneath it with its widened colour.
- R8: For alpha a from 1 to 14, each component equals floor((a*fg + (15-a)*bg + 7)/15).
- R9: While reset is asserted, and at the first cycles after it, the output pixel and all markers are 0.
- R10: A disabled plane's pixel and format select have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input pixel valid marker |
| inHsync | input | 1 | Input horizontal sync marker |
| inVsync | input | 1 | Input vertical sync marker |
| bgPixel | input | 16 | Background video pixel, RGB565 |
| l1Pixel | input | 16 | Layer 1 plane pixel |
| l2Pixel | input | 16 | Layer 2 plane pixel |
| l1Fmt | input | 1 | Layer 1 format: 0 RGB565, 1 ARGB4444 |
| l2Fmt | input | 1 | Layer 2 format: 0 RGB565, 1 ARGB4444 |
| l1En | input | 1 | Layer 1 enable |
| l2En | input | 1 | Layer 2 enable |
| outValid | output | 1 | Delayed valid marker |
| outHsync | output | 1 | Delayed horizontal sync marker |
| outVsync | output | 1 | Delayed vertical sync marker |
| outPixel | output | 16 | Composited RGB565 pixel |

## Verification
The assertions check on every cycle that the markers trail their inputs by exactly two cycles. They also check the cases where the output is fixed by one input two cycles earlier: both planes off passes the background, an opaque layer 2 passes its pixel, and a zero-alpha layer 2 over a disabled layer 1 passes the background.

Only the bench scenarios can show the arithmetic: that ARGB4444 fields are split and widened correctly, that intermediate alphas round to nearest, and that the two blends stack in the right order. The bench also covers the reset values and that a disabled plane's pixel and format select are ignored.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int PIX_W   = 16;
  localparam int ALPHA_W = 4;
  localparam int RED_W   = 5;
  localparam int GRN_W   = 6;
  localparam int BLU_W   = 5;

  // Strobes from control to datapath, one pair per pipeline stage.
  typedef struct packed {
    logic l1Use;
    logic l1Alpha;
    logic l2Use;
    logic l2Alpha;
  } ovl_strobe_t;
endpackage

// File: rtl/ovl_comp_blend.sv
module ovl_comp_blend #(
  parameter int W = 5,
  parameter int AW = 4
) (
  input  logic [W-1:0]  fg,
  input  logic [W-1:0]  bg,
  input  logic [AW-1:0] alpha,
  output logic [W-1:0]  res
);
  localparam int ACC_W = W + AW + 1;
  localparam int AMAX  = (1 << AW) - 1;

  logic [ACC_W-1:0] acc;

  always_comb begin
    acc = ACC_W'(alpha) * ACC_W'(fg)
        + ACC_W'(AW'(AMAX) - alpha) * ACC_W'(bg)
        + ACC_W'(AMAX / 2);
    res = W'(acc / ACC_W'(AMAX));
  end
endmodule

// File: rtl/ovl_layer_mix.sv
module ovl_layer_mix
  import ovl_pkg::*;
(
  input  logic [PIX_W-1:0] belowPix,
  input  logic [PIX_W-1:0] abovePix,
  input  logic             useLayer,
  input  logic             alphaFmt,
  output logic [PIX_W-1:0] mixPix
);
  logic [ALPHA_W-1:0] alpha;
  logic [RED_W-1:0]   wideR, mixR;
  logic [GRN_W-1:0]   wideG, mixG;
  logic [BLU_W-1:0]   wideB, mixB;

  assign alpha = abovePix[15:12];
  assign wideR = {abovePix[11:8], abovePix[11]};
  assign wideG = {abovePix[7:4],  abovePix[7:6]};
  assign wideB = {abovePix[3:0],  abovePix[3]};

  ovl_comp_blend #(.W(RED_W), .AW(ALPHA_W)) redI (
    .fg(wideR), .bg(belowPix[15:11]), .alpha(alpha), .res(mixR));
  ovl_comp_blend #(.W(GRN_W), .AW(ALPHA_W)) grnI (
    .fg(wideG), .bg(belowPix[10:5]),  .alpha(alpha), .res(mixG));
  ovl_comp_blend #(.W(BLU_W), .AW(ALPHA_W)) bluI (
    .fg(wideB), .bg(belowPix[4:0]),   .alpha(alpha), .res(mixB));

  always_comb begin
    if (!useLayer)     mixPix = belowPix;
    else if (!alphaFmt) mixPix = abovePix;
    else               mixPix = {mixR, mixG, mixB};
  end
endmodule

// File: rtl/ovl_ctrl.sv
module ovl_ctrl
  import ovl_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inHsync,
  input  logic        inVsync,
  input  logic        l1En,
  input  logic        l1Fmt,
  input  logic        l2En,
  input  logic        l2Fmt,
  output ovl_strobe_t stb,
  output logic        outValid,
  output logic        outHsync,
  output logic        outVsync
);
  localparam int MARK_W = 3;

  logic              l2EnQ, l2FmtQ;
  logic [MARK_W-1:0] markPipe [STAGES+1];

  assign markPipe[0] = {inValid, inHsync, inVsync};

  // Markers travel through as many registers as the pixel stages.
  for (genvar s = 0; s < STAGES; s++) begin : gMark
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) markPipe[s+1] <= '0;
      else       markPipe[s+1] <= markPipe[s];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      l2EnQ  <= 1'b0;
      l2FmtQ <= 1'b0;
    end else begin
      l2EnQ  <= l2En;
      l2FmtQ <= l2Fmt;
    end
  end

  always_comb begin
    stb.l1Use   = l1En;
    stb.l1Alpha = l1Fmt;
    stb.l2Use   = l2EnQ;
    stb.l2Alpha = l2FmtQ;
  end

  assign {outValid, outHsync, outVsync} = markPipe[STAGES];
endmodule

// File: rtl/ovl_datapath.sv
module ovl_datapath
  import ovl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ovl_strobe_t      stb,
  input  logic [PIX_W-1:0] bgPixel,
  input  logic [PIX_W-1:0] l1Pixel,
  input  logic [PIX_W-1:0] l2Pixel,
  output logic [PIX_W-1:0] outPixel
);
  logic [PIX_W-1:0] s1Mix, s1Pix, l2Hold, s2Mix;

  ovl_layer_mix l1MixI (
    .belowPix(bgPixel), .abovePix(l1Pixel),
    .useLayer(stb.l1Use), .alphaFmt(stb.l1Alpha), .mixPix(s1Mix));

  ovl_layer_mix l2MixI (
    .belowPix(s1Pix), .abovePix(l2Hold),
    .useLayer(stb.l2Use), .alphaFmt(stb.l2Alpha), .mixPix(s2Mix));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Pix    <= '0;
      l2Hold   <= '0;
      outPixel <= '0;
    end else begin
      s1Pix    <= s1Mix;
      l2Hold   <= l2Pixel;
      outPixel <= s2Mix;
    end
  end
endmodule

// File: rtl/overlay_blender.sv
module overlay_blender
  import ovl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inHsync,
  input  logic        inVsync,
  input  logic [15:0] bgPixel,
  input  logic [15:0] l1Pixel,
  input  logic [15:0] l2Pixel,
  input  logic        l1Fmt,
  input  logic        l2Fmt,
  input  logic        l1En,
  input  logic        l2En,
  output logic        outValid,
  output logic        outHsync,
  output logic        outVsync,
  output logic [15:0] outPixel
);
  ovl_strobe_t stb;

  ovl_ctrl #(.STAGES(2)) ctrlI (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inHsync(inHsync), .inVsync(inVsync),
    .l1En(l1En), .l1Fmt(l1Fmt), .l2En(l2En), .l2Fmt(l2Fmt),
    .stb(stb),
    .outValid(outValid), .outHsync(outHsync), .outVsync(outVsync));

  ovl_datapath dpI (
    .clk(clk), .rstN(rstN), .stb(stb),
    .bgPixel(bgPixel), .l1Pixel(l1Pixel), .l2Pixel(l2Pixel),
    .outPixel(outPixel));
endmodule

// File: rtl/ovl_chk.sv
module ovl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inHsync,
  input logic        inVsync,
  input logic [15:0] bgPixel,
  input logic [15:0] l1Pixel,
  input logic [15:0] l2Pixel,
  input logic        l1Fmt,
  input logic        l2Fmt,
  input logic        l1En,
  input logic        l2En,
  input logic        outValid,
  input logic        outHsync,
  input logic        outVsync,
  input logic [15:0] outPixel
);
  logic [1:0] warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R1
  marker_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd2) |-> ({outValid, outHsync, outVsync} ==
                        $past({inValid, inHsync, inVsync}, 2)));

  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((warm == 2'd2) && $past(!l1En && !l2En, 2)) |-> (outPixel == $past(bgPixel, 2)));

  // R3
  opaque_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((warm == 2'd2) && $past(l2En && !l2Fmt, 2)) |-> (outPixel == $past(l2Pixel, 2)));

  // R6
  clear_alpha_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((warm == 2'd2) && $past(!l1En && l2En && l2Fmt && (l2Pixel[15:12] == 4'd0), 2))
      |-> (outPixel == $past(bgPixel, 2)));
endmodule

bind overlay_blender ovl_chk chkI (.*);

// File: tb/overlay_blender_test.sv
module overlay_blender_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 0, inHsync = 0, inVsync = 0;
  logic [15:0] bgPixel = 0, l1Pixel = 0, l2Pixel = 0;
  logic l1Fmt = 0, l2Fmt = 0, l1En = 0, l2En = 0;
  logic outValid, outHsync, outVsync;
  logic [15:0] outPixel;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  overlay_blender uut (.*);

  // Independent reference built from R3, R5 and R8.
  function automatic int blendC(int fg, int bg, int a);
    return (a * fg + (15 - a) * bg + 7) / 15;
  endfunction

  function automatic logic [15:0] refMix(logic [15:0] below, logic [15:0] above,
                                         logic en, logic fmt);
    int a, r4, g4, b4, r5, g6, b5;
    if (!en) return below;
    if (!fmt) return above;
    a  = above[15:12];
    r4 = above[11:8]; g4 = above[7:4]; b4 = above[3:0];
    r5 = r4 * 2 + r4 / 8;
    g6 = g4 * 4 + g4 / 4;
    b5 = b4 * 2 + b4 / 8;
    return {5'(blendC(r5, below[15:11], a)),
            6'(blendC(g6, below[10:5], a)),
            5'(blendC(b5, below[4:0], a))};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [15:0] bg, logic [15:0] p1, logic [15:0] p2,
                       logic e1, logic f1, logic e2, logic f2);
    bgPixel = bg; l1Pixel = p1; l2Pixel = p2;
    l1En = e1; l1Fmt = f1; l2En = e2; l2Fmt = f2;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R9 pixel", 32'(outPixel), 32'h0);
    check("R9 markers", 32'({outValid, outHsync, outVsync}), 32'h0);
  endtask

  task automatic testBypass();
    drive(16'h1234, 16'hFFFF, 16'hABCD, 0, 0, 0, 1);
    check("R2 bypass", 32'(outPixel), 32'h1234);
    drive(16'h1234, 16'h0F0F, 16'h5555, 0, 1, 0, 0);
    check("R10 disabled ignored", 32'(outPixel), 32'h1234);
  endtask

  task automatic testOpaque();
    drive(16'h1234, 16'hF800, 16'h07E0, 1, 0, 0, 0);
    check("R3 opaque l1", 32'(outPixel), 32'hF800);
    drive(16'h1234, 16'hF800, 16'h07E0, 1, 0, 1, 0);
    check("R4 l2 above l1", 32'(outPixel), 32'h07E0);
  endtask

  task automatic testAlphaEnds();
    // A=F, R=A, G=5, B=3 -> widened 10101, 010101, 00110
    drive(16'h0000, 16'h0000, 16'hFA53, 0, 0, 1, 1);
    check("R5 R7 field widening", 32'(outPixel), 32'hAAA6);
    drive(16'h1234, 16'hF800, 16'h0FFF, 1, 0, 1, 1);
    check("R6 alpha zero", 32'(outPixel), 32'hF800);
    drive(16'h1234, 16'h0000, 16'h0FFF, 0, 0, 1, 1);
    check("R6 alpha zero over bg", 32'(outPixel), 32'h1234);
  endtask

  task automatic testMidAlpha();
    // a=8, fg black over white: red (8*0+7*31+7)/15 = 14
    drive(16'hFFFF, 16'h0000, 16'h8000, 0, 0, 1, 1);
    check("R8 red a=8", 32'(outPixel[15:11]), 32'd14);
    for (int a = 1; a < 15; a++) begin
      logic [15:0] p;
      p = {4'(a), 12'h9C4};
      drive(16'h5A3C, p, 16'h0, 1, 1, 0, 0);
      check("R8 alpha sweep", 32'(outPixel), 32'(refMix(16'h5A3C, p, 1, 1)));
    end
  endtask

  task automatic testStack();
    logic [15:0] mid;
    mid = refMix(16'h3C71, 16'h6E29, 1, 1);
    drive(16'h3C71, 16'h6E29, 16'hA1F8, 1, 1, 1, 1);
    check("R4 stacked alpha", 32'(outPixel), 32'(refMix(mid, 16'hA1F8, 1, 1)));
  endtask

  task automatic testLatency();
    logic [15:0] seq [4];
    seq[0] = 16'h1111; seq[1] = 16'h2222; seq[2] = 16'h3333; seq[3] = 16'h4444;
    l1En = 0; l2En = 0;
    inValid = 1; inHsync = 1; inVsync = 0; bgPixel = seq[0];
    @(posedge clk); @(negedge clk);
    check("R1 valid after 1", 32'(outValid), 32'h0);
    inValid = 0; inHsync = 0; inVsync = 1; bgPixel = seq[1];
    @(posedge clk); @(negedge clk);
    check("R1 markers after 2", 32'({outValid, outHsync, outVsync}), 32'h6);
    check("R1 pixel after 2", 32'(outPixel), 32'(seq[0]));
    inVsync = 0; bgPixel = seq[2];
    @(posedge clk); @(negedge clk);
    check("R1 vsync after 2", 32'({outValid, outHsync, outVsync}), 32'h1);
    check("R1 pixel stream", 32'(outPixel), 32'(seq[1]));
    bgPixel = seq[3];
    @(posedge clk); @(negedge clk);
    check("R1 markers clear", 32'({outValid, outHsync, outVsync}), 32'h0);
    check("R1 pixel stream 2", 32'(outPixel), 32'(seq[2]));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    testReset();
    testBypass();
    testOpaque();
    testAlphaEnds();
    testMidAlpha();
    testStack();
    testLatency();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule